// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a processor reach the management registers of an Ethernet PHY over the two-wire management interface. Software writes one 32-bit command word into the data register, and that write starts a frame on the management clock and data pins. The command word holds the start code, the opcode, the PHY address, the register address, the turnaround pattern and the write data. Each frame begins with 32 preamble ones, followed by the 32 bits of the word, most significant bit first.

When the frame ends, a sticky completion bit is set in the event register. For a read frame, the 16 bits returned by the PHY replace the low half of the data register. Software can poll the completion bit, or it can set the matching mask bit to get an interrupt. A divider field sets the rate of the management clock. The divider value is captured when each frame starts.

Top module: `mdio_master`

## Requirements
- R1: Register words are selected by regAddr: 0 is the event register, 1 the mask, 2 the data register and 3 the speed register. After reset, all four read 0, and mdc, mdioOe, mdioOut and irq are low.
- R2: A data write, while idle and with a nonzero speed field, starts a frame of 64 bits. The frame is 32 ones followed by the written word, MSB first. Each bit changes only after an mdc falling edge and is stable at the next rising edge.
- R3: While a frame runs, mdc is low for speed clocks and then high for speed clocks. The first rising edge comes speed clocks after the write edge. The event bit is set 128*speed clocks after the write edge, and mdc ends low.
- R4: The speed field occupies bits 6:1 of the speed register. All other bits are ignored on write and read as 0. The field is captured when a frame starts, so a change made during a frame affects only later frames.
- R5: A frame is a read frame when its word bits 29:28 are 10; any other opcode value gives a write frame. For a read frame, mdioOe is driven low from frame bit 47 (the second turnaround bit) through bit 63. For any other frame, mdioOe is driven high for all 64 bits. When idle, mdioOe is low, and mdioOut is low whenever mdioOe is low.
- R6: At the end of a read frame, data register bits 15:0 hold the 16 mdioIn values sampled on the mdc rising edges of frame bits 48..63, the first sample in bit 15. Bits 31:16 keep the written word. A write frame leaves the data register as written.
- R7: Event bit 23 is set when a frame ends. Writing 1 to bit 23 of the event register clears it, and writing 0 leaves it set. The other event bits read 0. A frame end in the same cycle as a clear leaves the bit set.
- R8: The mask register stores and reads back all 32 bits. irq is high exactly when some bit is set in both the event and mask registers, so with a zero mask irq stays low.
- R9: With a speed field of 0, mdc stays low and a data write starts no frame, although the data register still takes the written word.
- R10: A data write while a frame is running is ignored: the frame keeps its original bits, the data register keeps its value, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register word select |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| irq | output | 1 | Interrupt: event AND mask |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data out |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data in |

## Verification
Assertions check the following on every cycle:
- mdc stays low and mdioOe stays released whenever no frame is running.
- A zero speed field never starts a frame.
- The captured divider holds steady for a whole frame.
- Every frame end sets the event bit.
- A data write during a frame leaves the data register unchanged.

Only the bench scenarios can show the exact bit sequence on the pins, the clock period and the frame length for each divider, and the read data assembled from PHY responses across all 32 PHY addresses. The same holds for the write-one-to-clear and interrupt masking behaviour seen through the register port.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int WORD_W   = 32;
  localparam int PRE_LEN  = 32;
  localparam int FRAME_LEN = PRE_LEN + WORD_W;
  localparam int DATA_W   = 16;
  localparam int EVT_BIT  = 23;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef enum logic [1:0] {
    REG_EVENT = 2'd0,
    REG_MASK  = 2'd1,
    REG_DATA  = 2'd2,
    REG_SPEED = 2'd3
  } regSel_e;

  typedef struct packed {
    logic load;     // frame start: load shift register
    logic shift;    // falling edge: advance to next bit
    logic sample;   // rising edge: capture mdioIn
    logic done;     // frame end
    logic latchRx;  // frame end of a read frame
  } ctlStrobe_t;
endpackage

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWrite,
  input  logic [1:0]       opcode,
  input  logic [SPD_W-1:0] speedField,
  output logic             busy,
  output logic             mdc,
  output logic             mdioOe,
  output ctlStrobe_t       str
);
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  // second turnaround bit is word bit DATA_W
  localparam logic [CNT_W-1:0] RELEASE_IDX = CNT_W'(PRE_LEN + WORD_W - 1 - DATA_W);

  logic [SPD_W-1:0] divCnt;
  logic [SPD_W-1:0] divLatched;
  logic [CNT_W-1:0] bitCnt;
  logic             readFrame;
  logic             startGo;
  logic             halfEnd;

  always_comb begin
    startGo     = dataWrite && !busy && (speedField != '0);
    halfEnd     = busy && (divCnt == divLatched - SPD_W'(1));
    str.load    = startGo;
    str.sample  = halfEnd && !mdc;
    str.shift   = halfEnd && mdc && (bitCnt != LAST_IDX);
    str.done    = halfEnd && mdc && (bitCnt == LAST_IDX);
    str.latchRx = str.done && readFrame;
    mdioOe      = busy && !(readFrame && (bitCnt >= RELEASE_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      mdc        <= 1'b0;
      divCnt     <= '0;
      divLatched <= '0;
      bitCnt     <= '0;
      readFrame  <= 1'b0;
    end else if (startGo) begin
      busy       <= 1'b1;
      mdc        <= 1'b0;
      divCnt     <= '0;
      divLatched <= speedField;
      bitCnt     <= '0;
      readFrame  <= (opcode == OP_READ);
    end else if (busy) begin
      if (halfEnd) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (mdc) begin
          if (bitCnt == LAST_IDX) busy <= 1'b0;
          else bitCnt <= bitCnt + CNT_W'(1);
        end
      end else begin
        divCnt <= divCnt + SPD_W'(1);
      end
    end
  end

  assert_mdc_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  assert_oe_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);
  assert_no_zero_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && !busy && speedField == '0) |=> !busy);
  assert_div_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(divLatched));
  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(bitCnt) == LAST_IDX));
endmodule

// File: rtl/mdio_reg_dp.sv
module mdio_reg_dp
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWe,
  input  logic [WORD_W-1:0] regWdata,
  input  logic              busy,
  input  ctlStrobe_t        str,
  input  logic              mdioIn,
  output logic [WORD_W-1:0] regRdata,
  output logic              irq,
  output logic              txBit,
  output logic              dataWrite,
  output logic [SPD_W-1:0]  speedField
);
  logic                 evtBit;
  logic [WORD_W-1:0]    evtVec;
  logic [WORD_W-1:0]    maskReg;
  logic [WORD_W-1:0]    dataReg;
  logic [FRAME_LEN-1:0] txShift;
  logic [DATA_W-1:0]    rxShift;
  logic                 evtClear;

  always_comb begin
    dataWrite = regWe && (regAddr == REG_DATA);
    evtClear  = regWe && (regAddr == REG_EVENT) && regWdata[EVT_BIT];
    evtVec    = '0;
    evtVec[EVT_BIT] = evtBit;
    irq   = |(evtVec & maskReg);
    txBit = txShift[FRAME_LEN-1];
    case (regSel_e'(regAddr))
      REG_EVENT: regRdata = evtVec;
      REG_MASK:  regRdata = maskReg;
      REG_DATA:  regRdata = dataReg;
      default:   regRdata = {{(WORD_W-SPD_W-1){1'b0}}, speedField, 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtBit     <= 1'b0;
      maskReg    <= '0;
      dataReg    <= '0;
      speedField <= '0;
      txShift    <= '0;
      rxShift    <= '0;
    end else begin
      if (str.done) evtBit <= 1'b1;
      else if (evtClear) evtBit <= 1'b0;

      if (regWe && regAddr == REG_MASK) maskReg <= regWdata;
      if (regWe && regAddr == REG_SPEED) speedField <= regWdata[SPD_W:1];

      if (dataWrite && !busy) dataReg <= regWdata;
      else if (str.latchRx) dataReg[DATA_W-1:0] <= rxShift;

      if (str.load) txShift <= {{PRE_LEN{1'b1}}, regWdata};
      else if (str.shift) txShift <= {txShift[FRAME_LEN-2:0], 1'b0};

      if (str.sample) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
    end
  end

  assert_evt_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    str.done |=> evtBit);
  assert_busy_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrite && busy && !str.latchRx) |=> $stable(dataReg));
  assert_preamble_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    str.load |=> (txShift[FRAME_LEN-1 -: PRE_LEN] == {PRE_LEN{1'b1}}));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  ctlStrobe_t       str;
  logic             busy;
  logic             dataWrite;
  logic             txBit;
  logic [SPD_W-1:0] speedField;

  mdio_frame_ctl #(.SPD_W(SPD_W)) uCtl (
    .clk(clk), .rstN(rstN), .dataWrite(dataWrite), .opcode(regWdata[29:28]),
    .speedField(speedField), .busy(busy), .mdc(mdc), .mdioOe(mdioOe), .str(str)
  );

  mdio_reg_dp #(.SPD_W(SPD_W)) uDp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .busy(busy), .str(str), .mdioIn(mdioIn), .regRdata(regRdata), .irq(irq),
    .txBit(txBit), .dataWrite(dataWrite), .speedField(speedField)
  );

  assign mdioOut = txBit & mdioOe;
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq, mdc, mdioOut, mdioOe;
  logic mdioIn = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wrCyc = 0;
  int frameT0 = 0;
  int riseIdx = 0;
  logic [15:0] phyData = '0;
  logic capBits [0:63];
  logic capOe [0:63];
  int riseCyc [0:63];

  mdio_master u0 (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  always #10 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // PHY model: record each rising edge, present read data for the next one
  initial forever begin
    @(posedge mdc);
    if (riseIdx < 64) begin
      capBits[riseIdx] = mdioOut;
      capOe[riseIdx] = mdioOe;
      riseCyc[riseIdx] = cyc;
    end
    riseIdx = riseIdx + 1;
    #1;
    if (riseIdx >= 48 && riseIdx <= 63) mdioIn = phyData[63 - riseIdx];
    else mdioIn = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    wrCyc = cyc;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic startFrame(input logic [31:0] word, input logic [15:0] pd);
    riseIdx = 0;
    phyData = pd;
    wrReg(2'd2, word);
    frameT0 = wrCyc;
  endtask

  task automatic finishFrame(input logic [31:0] word, input int dv, input logic [15:0] pd);
    logic [31:0] v;
    logic [63:0] gotBits, expBits, gotOe, expOe;
    int doneCyc;
    bit isRd;
    doneCyc = -1;
    isRd = (word[29:28] == 2'b10);
    for (int k = 0; k < 128 * dv + 40; k++) begin
      rdReg(2'd0, v);
      if (v[23]) begin doneCyc = cyc; break; end
    end
    chk("R3 frame length", 64'(doneCyc - frameT0), 64'(128 * dv));
    chk("R2 rising edge count", 64'(riseIdx), 64'd64);
    if (riseIdx >= 64) begin
      for (int i = 0; i < 64; i++) begin
        gotBits[63-i] = capBits[i];
        gotOe[63-i] = capOe[i];
        expOe[63-i] = !(isRd && i >= 47);
      end
      expBits = {32'hFFFF_FFFF, word} & expOe;
      chk("R2 frame bits", gotBits, expBits);
      chk("R5 output enable pattern", gotOe, expOe);
      chk("R3 first rise", 64'(riseCyc[0] - frameT0), 64'(dv));
      chk("R3 mdc period", 64'(riseCyc[63] - riseCyc[0]), 64'(126 * dv));
    end
    chk("R3 R5 idle pins", {62'd0, mdc, mdioOe}, 64'd0);
    rdReg(2'd2, v);
    chk("R6 data register", 64'(v), 64'(isRd ? {word[31:16], pd} : word));
    wrReg(2'd0, 32'h0080_0000);
  endtask

  task automatic runFrame(input logic [31:0] word, input int dv, input logic [15:0] pd);
    startFrame(word, pd);
    finishFrame(word, dv, pd);
  endtask

  function automatic logic [31:0] mkCmd(input bit rd, input logic [4:0] pa,
                                        input logic [4:0] ra, input logic [15:0] val);
    return {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, rd ? 16'h0000 : val};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), v);
      chk("R1 reset register", 64'(v), 64'd0);
    end
    chk("R1 reset pins", {60'd0, mdc, mdioOe, mdioOut, irq}, 64'd0);

    // R4 speed field placement
    wrReg(2'd3, 32'hFFFF_FFFF);
    rdReg(2'd3, v);
    chk("R4 speed readback", 64'(v), 64'h7E);

    // R9 zero speed
    wrReg(2'd3, 32'h0);
    riseIdx = 0;
    wrReg(2'd2, 32'h5A5A_1234);
    repeat (300) @(negedge clk);
    chk("R9 no mdc edges", 64'(riseIdx), 64'd0);
    rdReg(2'd0, v);
    chk("R9 no event", 64'(v), 64'd0);
    rdReg(2'd2, v);
    chk("R9 word stored", 64'(v), 64'h5A5A_1234);

    // R2 R3 R5 R6 sweep over dividers and frame kinds
    for (int dv = 1; dv <= 3; dv++) begin
      wrReg(2'd3, 32'(dv << 1));
      runFrame(mkCmd(1'b0, 5'd3, 5'd0, 16'hBEEF), dv, 16'h0);
      runFrame(mkCmd(1'b1, 5'd17, 5'd2, 16'h0), dv, 16'h8001 ^ 16'(dv * 16'h0F0F));
      runFrame(mkCmd(1'b0, 5'd31, 5'd31, 16'h0000), dv, 16'h0);
      runFrame(32'h7000_0000 | 32'(dv), dv, 16'h0); // opcode 11 acts as write
    end

    // R6 read sweep over all PHY addresses
    wrReg(2'd3, 32'd2);
    for (int pa = 0; pa < 32; pa++)
      runFrame(mkCmd(1'b1, 5'(pa), 5'(31 - pa), 16'h0), 1, 16'hA5C3 ^ 16'(pa * 16'h1111));

    // R7 R8 event and interrupt mask
    runFrame(mkCmd(1'b0, 5'd1, 5'd4, 16'h1357), 1, 16'h0);
    startFrame(mkCmd(1'b0, 5'd1, 5'd4, 16'h1357), 16'h0);
    repeat (140) @(negedge clk);
    rdReg(2'd0, v);
    chk("R7 event set", 64'(v), 64'h0080_0000);
    chk("R8 irq low with zero mask", 64'(irq), 64'd0);
    wrReg(2'd1, 32'hFFFF_FFFF);
    rdReg(2'd1, v);
    chk("R8 mask readback", 64'(v), 64'hFFFF_FFFF);
    #1 chk("R8 irq high", 64'(irq), 64'd1);
    wrReg(2'd0, 32'hFF7F_FFFF);
    rdReg(2'd0, v);
    chk("R7 write zero keeps event", 64'(v), 64'h0080_0000);
    wrReg(2'd0, 32'h0080_0000);
    rdReg(2'd0, v);
    chk("R7 write one clears", 64'(v), 64'd0);
    #1 chk("R8 irq follows clear", 64'(irq), 64'd0);
    wrReg(2'd1, 32'h0);

    // R10 write during frame ignored
    wrReg(2'd3, 32'd4);
    startFrame(mkCmd(1'b0, 5'd9, 5'd9, 16'hC0DE), 16'h0);
    repeat (40) @(negedge clk);
    wrReg(2'd2, 32'h6FFF_FFFF);
    finishFrame(mkCmd(1'b0, 5'd9, 5'd9, 16'hC0DE), 2, 16'h0);
    repeat (400) @(negedge clk);
    chk("R10 no second frame", 64'(riseIdx), 64'd64);

    // R4 divider captured at frame start
    wrReg(2'd3, 32'd2);
    startFrame(mkCmd(1'b1, 5'd5, 5'd1, 16'h0), 16'h4321);
    repeat (20) @(negedge clk);
    wrReg(2'd3, 32'd6);
    finishFrame(mkCmd(1'b1, 5'd5, 5'd1, 16'h0), 1, 16'h4321);
    runFrame(mkCmd(1'b0, 5'd5, 5'd1, 16'h2222), 3, 16'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule